// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and the next memory level. Processor stores are captured in a small set of entries, so the processor continues without waiting for memory. Each entry covers one aligned block of several words and keeps one valid bit per word. A store to a block that already has a pending, mergeable entry is folded into that entry rather than taking a new one. Entries leave in allocation order, each as a single masked multi-word write on a valid/ready memory port.

Loads are looked up in the same entries. A load whose word is buffered gets the newest buffered copy. A load that touches a pending block whose word has not been written is told to wait until the drain. A load that matches nothing may go to memory at once, ahead of the buffered writes.

The entry currently offered on the memory port is locked. A store to its block opens a new entry, or stalls when no entry is free.

Top module: `wbm_top`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, `mw_valid` is 0, and `ld_hit` and `ld_wait` are 0 for any load.
- R2: While fewer than `N_ENT` entries are occupied, `st_ready` is 1. A store is taken at the clock edge where `st_valid` and `st_ready` are both 1.
- R3: A store whose block address equals that of an occupied entry other than the one on the memory port is accepted even when every entry is full. It overwrites the addressed word and sets that word's valid bit.
- R4: When all entries are occupied and no mergeable entry matches, `st_ready` is 0, and the store waits until an entry drains.
- R5: A load whose word is valid in a matching entry raises `ld_hit`, and `ld_data` carries the word from the most recently allocated such entry.
- R6: A load whose block matches no occupied entry leaves both `ld_hit` and `ld_wait` at 0.
- R7: A load whose block matches an occupied entry, but whose word is valid in none of them, raises `ld_wait`.
- R8: Entries drain oldest first. `mw_addr` is the block address, bit k of `mw_mask` marks word k as written, and word k sits at `mw_data[k*DW +: DW]`. The offer is held unchanged until `mw_ready` is 1.
- R9: The entry on the memory port never takes a merge. A store to its block allocates a separate, newer entry, which drains afterwards.
- R10: The word index is the low log2(`WPE`) bits of `st_addr` and `ld_addr`, and the block address is the remaining high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store can be taken this cycle |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load word address |
| ld_hit | output | 1 | Load served from buffer |
| ld_wait | output | 1 | Load must wait for drain |
| ld_data | output | DW | Forwarded load data |
| mw_valid | output | 1 | Memory write offered |
| mw_ready | input | 1 | Memory accepts write |
| mw_addr | output | AW-log2(WPE) | Block address of the write |
| mw_mask | output | WPE | Written-word mask |
| mw_data | output | WPE*DW | Block data, word k at k*DW |

## Verification
Every cycle, the assertions check the following. Stores are never refused while an entry is free. A refusal happens only with all entries occupied. At most one entry is a merge candidate. The offer on the memory port holds steady while back-pressured and carries a non-empty mask. A load never reports hit and wait together. Occupancy grows by one on an allocation without a drain. Only the bench scenarios can show that the forwarded data is the newest value, that drains leave in allocation order with the right masks, and that after a permuted sweep with repeated stores and irregular back-pressure, memory ends up holding exactly the last value stored to each of the 64 words.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  // Decoded action for the store presented in the current cycle.
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_MERGE = 2'd1,
    ACT_ALLOC = 2'd2,
    ACT_STALL = 2'd3
  } st_act_e;
endpackage

// File: rtl/wbm_lookup.sv
// Block-address comparator across all entries.
module wbm_lookup #(
  parameter int N_ENT = 4,
  parameter int BW    = 4
) (
  input  logic [N_ENT-1:0]         vld,
  input  logic [N_ENT-1:0][BW-1:0] blk,
  input  logic [BW-1:0]            key,
  output logic [N_ENT-1:0]         hit
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hit[i] = vld[i] && (blk[i] == key);
  end
endmodule

// File: rtl/wbm_age_sel.sv
// Picks the youngest candidate, counting age from the ring head.
module wbm_age_sel #(
  parameter int N_ENT = 4,
  parameter int IW    = 2
) (
  input  logic [IW-1:0]    head,
  input  logic [N_ENT-1:0] cand,
  output logic             any,
  output logic [IW-1:0]    idx
);
  always_comb begin
    any = 1'b0;
    idx = head;
    for (int a = 0; a < N_ENT; a++) begin
      logic [IW:0] sum;
      sum = {1'b0, head} + (IW+1)'(a);
      if (sum >= (IW+1)'(N_ENT)) sum = sum - (IW+1)'(N_ENT);
      if (cand[sum[IW-1:0]]) begin
        any = 1'b1;
        idx = sum[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/wbm_ring_ctl.sv
// Head/tail pointers and occupancy for the entry ring.
module wbm_ring_ctl #(
  parameter int N_ENT = 4,
  parameter int IW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic [CW-1:0] occ
);
  logic [IW-1:0] head_d, tail_d;
  logic [CW-1:0] occ_d;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
    return (p == IW'(N_ENT-1)) ? '0 : p + IW'(1);
  endfunction

  always_comb begin
    head_d = pop  ? step(head) : head;
    tail_d = push ? step(tail) : tail;
    occ_d  = occ;
    if (push && !pop) occ_d = occ + CW'(1);
    if (pop && !push) occ_d = occ - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else if (push || pop) begin
      head <= head_d;
      tail <= tail_d;
      occ  <= occ_d;
    end
  end
endmodule

// File: rtl/wbm_top.sv
module wbm_top
  import wbm_pkg::*;
#(
  parameter int N_ENT = 4,
  parameter int WPE   = 4,
  parameter int DW    = 32,
  parameter int AW    = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          st_valid,
  input  logic [AW-1:0]                 st_addr,
  input  logic [DW-1:0]                 st_data,
  output logic                          st_ready,
  input  logic                          ld_valid,
  input  logic [AW-1:0]                 ld_addr,
  output logic                          ld_hit,
  output logic                          ld_wait,
  output logic [DW-1:0]                 ld_data,
  output logic                          mw_valid,
  input  logic                          mw_ready,
  output logic [AW-$clog2(WPE)-1:0]     mw_addr,
  output logic [WPE-1:0]                mw_mask,
  output logic [WPE*DW-1:0]             mw_data
);
  localparam int OW = $clog2(WPE);
  localparam int BW = AW - OW;
  localparam int IW = $clog2(N_ENT);
  localparam int CW = $clog2(N_ENT + 1);

  // Entry state
  logic [N_ENT-1:0]                    vld_q, vld_d;
  logic [N_ENT-1:0][WPE-1:0]           mask_q, mask_d;
  logic [N_ENT-1:0][BW-1:0]            blk_q, blk_d;
  logic [N_ENT-1:0][WPE-1:0][DW-1:0]   data_q, data_d;

  logic [IW-1:0] head, tail;
  logic [CW-1:0] occ;
  logic          full, push, pop, data_en;
  st_act_e       st_act;

  // Address split
  logic [BW-1:0] st_blk, ld_blk;
  logic [OW-1:0] st_widx, ld_widx;
  assign st_blk  = st_addr[AW-1:OW];
  assign st_widx = st_addr[OW-1:0];
  assign ld_blk  = ld_addr[AW-1:OW];
  assign ld_widx = ld_addr[OW-1:0];

  // Store match: the head entry is locked while offered to memory
  logic [N_ENT-1:0] st_bhit, mg_cand;
  logic             mg_any;
  logic [IW-1:0]    mg_idx;

  wbm_lookup #(.N_ENT(N_ENT), .BW(BW)) st_lkp_i (
    .vld(vld_q), .blk(blk_q), .key(st_blk), .hit(st_bhit)
  );

  always_comb begin
    mg_cand       = st_bhit;
    mg_cand[head] = 1'b0;
  end

  wbm_age_sel #(.N_ENT(N_ENT), .IW(IW)) mg_sel_i (
    .head(head), .cand(mg_cand), .any(mg_any), .idx(mg_idx)
  );

  assign full = (occ == CW'(N_ENT));

  always_comb begin
    if (!st_valid)   st_act = ACT_IDLE;
    else if (mg_any) st_act = ACT_MERGE;
    else if (!full)  st_act = ACT_ALLOC;
    else             st_act = ACT_STALL;
  end

  assign st_ready = mg_any || !full;
  assign push     = (st_act == ACT_ALLOC);
  assign pop      = mw_valid && mw_ready;
  assign data_en  = (st_act == ACT_MERGE) || (st_act == ACT_ALLOC);

  wbm_ring_ctl #(.N_ENT(N_ENT), .IW(IW), .CW(CW)) ring_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head(head), .tail(tail), .occ(occ)
  );

  // Next-state for entries
  always_comb begin
    vld_d  = vld_q;
    mask_d = mask_q;
    blk_d  = blk_q;
    data_d = data_q;
    if (pop) vld_d[head] = 1'b0;
    case (st_act)
      ACT_MERGE: begin
        mask_d[mg_idx][st_widx] = 1'b1;
        data_d[mg_idx][st_widx] = st_data;
      end
      ACT_ALLOC: begin
        vld_d[tail]           = 1'b1;
        blk_d[tail]           = st_blk;
        mask_d[tail]          = '0;
        mask_d[tail][st_widx] = 1'b1;
        data_d[tail][st_widx] = st_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      mask_q <= '0;
    end else begin
      vld_q  <= vld_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      blk_q  <= blk_d;
      data_q <= data_d;
    end
  end

  // Drain port: head entry
  assign mw_valid = vld_q[head];
  assign mw_addr  = blk_q[head];
  assign mw_mask  = mask_q[head];
  assign mw_data  = data_q[head];

  // Load lookup
  logic [N_ENT-1:0] ld_bhit, ld_whit;
  logic             ld_any;
  logic [IW-1:0]    ld_sel;

  wbm_lookup #(.N_ENT(N_ENT), .BW(BW)) ld_lkp_i (
    .vld(vld_q), .blk(blk_q), .key(ld_blk), .hit(ld_bhit)
  );

  for (genvar i = 0; i < N_ENT; i++) begin : g_whit
    assign ld_whit[i] = ld_bhit[i] && mask_q[i][ld_widx];
  end

  wbm_age_sel #(.N_ENT(N_ENT), .IW(IW)) ld_age_i (
    .head(head), .cand(ld_whit), .any(ld_any), .idx(ld_sel)
  );

  assign ld_hit  = ld_valid && ld_any;
  assign ld_wait = ld_valid && (|ld_bhit) && !ld_any;
  assign ld_data = data_q[ld_sel][ld_widx];
endmodule

// File: rtl/wbm_chk.sv
module wbm_chk
  import wbm_pkg::*;
#(
  parameter int N_ENT = 4,
  parameter int WPE   = 4,
  parameter int DW    = 32,
  parameter int BW    = 8,
  parameter int CW    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_ready,
  input logic [CW-1:0]     occ,
  input logic [N_ENT-1:0]  mg_cand,
  input st_act_e           st_act,
  input logic              mw_valid,
  input logic              mw_ready,
  input logic [BW-1:0]     mw_addr,
  input logic [WPE-1:0]    mw_mask,
  input logic [WPE*DW-1:0] mw_data,
  input logic              ld_hit,
  input logic              ld_wait
);
  p_room_accepts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < CW'(N_ENT)) |-> st_ready);

  p_stall_only_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> (occ == CW'(N_ENT)));

  p_one_merge_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mg_cand) <= 1);

  p_offer_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr)
                                 && $stable(mw_mask) && $stable(mw_data)));

  p_mask_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> (mw_mask != '0));

  p_hit_wait_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_wait));

  p_alloc_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_act == ACT_ALLOC) && !(mw_valid && mw_ready)) |=> (occ == $past(occ) + CW'(1)));
endmodule

bind wbm_top wbm_chk #(
  .N_ENT(N_ENT), .WPE(WPE), .DW(DW), .BW(AW-$clog2(WPE)), .CW($clog2(N_ENT+1))
) chk_i (
  .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .occ(occ), .mg_cand(mg_cand),
  .st_act(st_act), .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
  .mw_mask(mw_mask), .mw_data(mw_data), .ld_hit(ld_hit), .ld_wait(ld_wait)
);

// File: tb/wbm_top_tb_top.sv
module wbm_top_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int N_ENT = 4;
  localparam int WPE   = 4;
  localparam int DW    = 32;
  localparam int AW    = 6;
  localparam int BW    = AW - 2;
  localparam int NW    = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready;
  logic ld_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic ld_hit, ld_wait;
  logic [DW-1:0] ld_data;
  logic mw_valid;
  logic mw_ready;
  logic [BW-1:0] mw_addr;
  logic [WPE-1:0] mw_mask;
  logic [WPE*DW-1:0] mw_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int rdy_mode = 0;  // 0: never ready, 1: always ready, 2: irregular
  int cyc = 0;

  logic [DW-1:0] ref_mem [NW];
  logic [DW-1:0] mem     [NW];
  logic [BW-1:0]     log_addr [64];
  logic [WPE-1:0]    log_mask [64];
  logic [WPE*DW-1:0] log_data [64];
  int log_n = 0;

  always #2.5 clk = ~clk;

  wbm_top #(.N_ENT(N_ENT), .WPE(WPE), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_ready(st_ready), .ld_valid(ld_valid),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_wait(ld_wait), .ld_data(ld_data),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_mask(mw_mask), .mw_data(mw_data)
  );

  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      1:       mw_ready = 1'b1;
      2:       mw_ready = ((cyc % 3) != 0);
      default: mw_ready = 1'b0;
    endcase
  end

  // Memory model: masked block write
  always @(posedge clk) begin
    if (rst_n && mw_valid && mw_ready) begin
      for (int k = 0; k < WPE; k++)
        if (mw_mask[k]) mem[int'(mw_addr)*WPE + k] = mw_data[k*DW +: DW];
      if (log_n < 64) begin
        log_addr[log_n] = mw_addr;
        log_mask[log_n] = mw_mask;
        log_data[log_n] = mw_data;
      end
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    ref_mem[a] = d;
    #1 st_valid = 1'b0;
  endtask

  // Present a store without letting an edge pass; return st_ready
  task automatic probe(input logic [AW-1:0] a, output logic rdy);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = 32'hDEAD_BEEF;
    #1 rdy = st_ready;
    st_valid = 1'b0;
  endtask

  task automatic load(input logic [AW-1:0] a, output logic h, output logic w, output logic [DW-1:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a;
    #1 h = ld_hit; w = ld_wait; d = ld_data;
    ld_valid = 1'b0;
  endtask

  task automatic drain_all();
    rdy_mode = 1;
    do @(negedge clk); while (mw_valid);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic r, h, w;
    logic [DW-1:0] d;
    for (int i = 0; i < NW; i++) begin ref_mem[i] = '0; mem[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    ld_valid = 1'b1; ld_addr = 6'h00;
    #1;
    chk(st_ready == 1'b1, "R1 st_ready", 32'(st_ready), 32'd1);
    chk(mw_valid == 1'b0, "R1 mw_valid", 32'(mw_valid), 32'd0);
    chk(!ld_hit && !ld_wait, "R1 load idle", {30'd0, ld_hit, ld_wait}, 32'd0);
    ld_valid = 1'b0;

    // R2: fill four distinct blocks, memory held off
    probe(6'h00, r); chk(r, "R2 ready empty", 32'(r), 32'd1);
    store(6'h00, 32'h1000_0000);
    store(6'h05, 32'h1000_0005);
    store(6'h0A, 32'h1000_000A);
    probe(6'h0F, r); chk(r, "R2 ready one free", 32'(r), 32'd1);
    store(6'h0F, 32'h1000_000F);

    // R4: full, new block stalls
    probe(6'h10, r); chk(!r, "R4 stall full", 32'(r), 32'd0);
    // R9: head block is locked
    probe(6'h01, r); chk(!r, "R9 head no merge", 32'(r), 32'd0);
    // R3: merge into non-head entry while full
    probe(6'h08, r); chk(r, "R3 merge ready", 32'(r), 32'd1);
    store(6'h08, 32'h2000_0008);

    // R8: offer held under back-pressure
    #1;
    chk(mw_valid && mw_addr == 4'd0, "R8 head held", 32'(mw_addr), 32'd0);

    // Loads
    load(6'h08, h, w, d);
    chk(h && d == 32'h2000_0008, "R3 R5 merged word", d, 32'h2000_0008);
    load(6'h0A, h, w, d);
    chk(h && d == 32'h1000_000A, "R5 forward", d, 32'h1000_000A);
    load(6'h09, h, w, d);
    chk(w && !h, "R7 partial wait", {30'd0, h, w}, 32'd1);
    load(6'h03, h, w, d);
    chk(w && !h, "R7 head partial", {30'd0, h, w}, 32'd1);
    load(6'h30, h, w, d);
    chk(!w && !h, "R6 no match", {30'd0, h, w}, 32'd0);

    // R8: drain order and masks
    drain_all();
    rdy_mode = 0;
    chk(log_n == 4, "R8 drain count", 32'(log_n), 32'd4);
    for (int k = 0; k < 4; k++)
      chk(log_addr[k] == BW'(k), "R8 drain order", 32'(log_addr[k]), 32'(k));
    chk(log_mask[2] == 4'b0101, "R8 merged mask", 32'(log_mask[2]), 32'h5);
    chk(log_data[2][0 +: DW] == 32'h2000_0008, "R8 word0 lane", log_data[2][0 +: DW], 32'h2000_0008);
    chk(log_data[2][2*DW +: DW] == 32'h1000_000A, "R8 word2 lane", log_data[2][2*DW +: DW], 32'h1000_000A);
    chk(log_mask[3] == 4'b1000, "R8 mask word3", 32'(log_mask[3]), 32'h8);

    // R9: second store to head block opens a newer entry
    store(6'h14, 32'hAAAA_0000);
    store(6'h14, 32'hBBBB_0000);
    load(6'h14, h, w, d);
    chk(h && d == 32'hBBBB_0000, "R9 R5 newest wins", d, 32'hBBBB_0000);
    load(6'h15, h, w, d);
    chk(w && !h, "R7 missing word", {30'd0, h, w}, 32'd1);
    store(6'h15, 32'hCCCC_0000);
    drain_all();
    rdy_mode = 0;
    chk(log_n == 6, "R9 two entries", 32'(log_n), 32'd6);
    chk(log_mask[4] == 4'b0001 && log_data[4][0 +: DW] == 32'hAAAA_0000, "R9 older first",
        log_data[4][0 +: DW], 32'hAAAA_0000);
    chk(log_mask[5] == 4'b0011 && log_data[5][DW +: DW] == 32'hCCCC_0000, "R9 merge into newer",
        log_data[5][DW +: DW], 32'hCCCC_0000);
    chk(log_data[5][0 +: DW] == 32'hBBBB_0000, "R9 newer word0", log_data[5][0 +: DW], 32'hBBBB_0000);

    // Sweep: every word address twice, irregular memory back-pressure
    rdy_mode = 2;
    for (int i = 0; i < 2*NW; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] v;
      a = AW'((i*37 + 11) % NW);
      v = 32'h5A00_0000 | 32'(i);
      store(a, v);
      load(a, h, w, d);
      chk(h && d == v, "R5 sweep forward", d, v);
    end
    drain_all();
    for (int i = 0; i < NW; i++)
      chk(mem[i] == ref_mem[i], "R10 R8 final memory", mem[i], ref_mem[i]);

    // R6: empty buffer, every address misses cleanly
    for (int i = 0; i < NW; i++) begin
      load(AW'(i), h, w, d);
      chk(!h && !w, "R6 empty sweep", {30'd0, h, w}, 32'd0);
    end
    #1;
    chk(st_ready && !mw_valid, "R2 idle after drain", {30'd0, st_ready, mw_valid}, 32'd2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule